// File: doc/BRIEF.md
# DDR2 Bank Timing Guard

The guard sits on a DDR2 command bus and checks every command against the per-bank timing rules of the memory. Each cycle it decodes chip-select, RAS, CAS and WE together with the bank address. For every bank it keeps an idle or active state and two saturating cycle counters: one since the last activate and one since the last precharge. A third counter records the time since the last activate to any bank.

For each activate, read, write and precharge, the guard raises either `cmd_ok_o` or `viol_o` in the same cycle as the command. A violation also reports the bank and a violation code. The checked parameters are:

- RAS-to-CAS delay
- row active time
- row precharge time
- row cycle time
- spacing between activates to different banks

All timing values are run-time inputs in clock units. A posted read or write is checked at its internal issue cycle, which is the bus cycle plus the programmed additive latency. On an eight-bank configuration, a bank closed by a precharge-all needs one extra clock before it can be reopened.

Top module: `ddr2_bank_guard`

## Requirements
- R1: Commands are decoded with cs_n low as follows, with {ras_n,cas_n,we_n}:
  - activate is 011.
  - read is 101.
  - write is 100.
  - precharge is 010.
  - Any other pattern, or cs_n high, raises neither cmd_ok_o nor viol_o.
- R2: For each decoded command, exactly one of cmd_ok_o and viol_o is high in that same cycle. When viol_o is high, viol_code_o is nonzero and viol_bank_o names the offending bank.
- R3: An activate to a bank that is already active is a violation with code 1.
- R4: An activate issued fewer than t_rc_i cycles after the previous activate to the same bank is a violation with code 2.
- R5: An activate issued fewer than t_rp_i cycles after that bank's last precharge is a violation with code 3. If the last precharge was a precharge-all and the configuration has eight banks, the limit is t_rp_i+1.
- R6: An activate issued fewer than t_rrd_i cycles after an activate to any bank is a violation with code 4.
- R7: A read or write to an idle bank is a violation with code 5.
- R8: A read or write to an active bank violates with code 6 when the cycles since its activate plus al_i is less than t_rcd_i. The value of al_i is 0 to 6.
- R9: A single-bank precharge (pre_all_sel_i low) to an active bank fewer than t_ras_i cycles after its activate is a violation with code 7. A precharge to an idle bank is legal.
- R10: A precharge-all (pre_all_sel_i high) violates with code 7 if any active bank is younger than t_ras_i, and reports the lowest such bank. Afterwards every bank is idle.
- R11: After reset all banks are idle and all counters read as satisfied. With no command, both indications are low, and the first activate is legal for any timing values.
- R12: Activate checks apply in the priority order of codes 1, 2, 3, 4. Bank state follows every decoded command, whether it is legal or not. Cycle counts saturate at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address |
| pre_all_sel_i | input | 1 | Address bit that selects all banks on a precharge |
| t_rcd_i | input | CNT_W | Activate-to-read/write delay, in clocks |
| t_ras_i | input | CNT_W | Activate-to-precharge minimum, in clocks |
| t_rp_i | input | CNT_W | Precharge-to-activate minimum, in clocks |
| t_rc_i | input | CNT_W | Activate-to-activate minimum for the same bank, in clocks |
| t_rrd_i | input | CNT_W | Activate-to-activate minimum for different banks, in clocks |
| al_i | input | 3 | Additive latency, 0 to 6 |
| cmd_ok_o | output | 1 | Command is legal |
| viol_o | output | 1 | Command violates a rule |
| viol_bank_o | output | BA_W | Bank that caused the violation |
| viol_code_o | output | 3 | Violation code, 1 to 7 |

## Verification
The verdict is combinational and applies to the command on the bus in that same cycle. The tracked state changes at the following rising edge, so a second command issued k edges later sees a gap of k. The bench drives each command at the falling edge and samples the outputs 2 ns later. It advances its own cycle-stamped model at the next rising edge, which reproduces the design's one-register delay without looking inside it. Gap sweeps over every additive latency then place each read, precharge and activate exactly at, one cycle before, and one cycle after every limit.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    VC_NONE = 3'd0,
    VC_OPEN = 3'd1,
    VC_RC   = 3'd2,
    VC_RP   = 3'd3,
    VC_RRD  = 3'd4,
    VC_IDLE = 3'd5,
    VC_RCD  = 3'd6,
    VC_RAS  = 3'd7
  } viol_e;
endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
  import ddr2_guard_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic pre_all_sel_i,
  output cmd_e cmd_o,
  output logic pre_all_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (!cs_n_i) begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        default: cmd_o = CMD_NONE;
      endcase
    end
  end

  assign pre_all_o = (cmd_o == CMD_PRE) && pre_all_sel_i;
endmodule

// File: rtl/ddr2_sat_cnt.sv
module ddr2_sat_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // reset value is the saturated count: the limit reads as already met
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= SAT;
    else if (clr_i)       cnt_o <= ONE;
    else if (cnt_o != SAT) cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             pre_all_i,
  output logic             active_o,
  output logic             pall_o,
  output logic [CNT_W-1:0] since_act_o,
  output logic [CNT_W-1:0] since_pre_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      pall_o   <= 1'b0;
    end else if (act_i) begin
      active_o <= 1'b1;
    end else if (pre_i) begin
      active_o <= 1'b0;
      pall_o   <= pre_all_i;
    end
  end

  ddr2_sat_cnt #(.CNT_W(CNT_W)) i_act_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (act_i),
    .cnt_o  (since_act_o)
  );

  ddr2_sat_cnt #(.CNT_W(CNT_W)) i_pre_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_i),
    .cnt_o  (since_pre_o)
  );
endmodule

// File: rtl/ddr2_rule_check.sv
module ddr2_rule_check
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int CNT_W      = 6,
  parameter int AL_W       = 3,
  parameter bit PALL_EXTRA = 1'b1,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  cmd_e                            cmd_i,
  input  logic [BA_W-1:0]                 bank_i,
  input  logic                            pre_all_i,
  input  logic [NUM_BANKS-1:0]            active_i,
  input  logic [NUM_BANKS-1:0]            pall_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] since_act_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] since_pre_i,
  input  logic [CNT_W-1:0]                since_any_act_i,
  input  logic [CNT_W-1:0]                t_rcd_i,
  input  logic [CNT_W-1:0]                t_ras_i,
  input  logic [CNT_W-1:0]                t_rp_i,
  input  logic [CNT_W-1:0]                t_rc_i,
  input  logic [CNT_W-1:0]                t_rrd_i,
  input  logic [AL_W-1:0]                 al_i,
  output logic                            ok_o,
  output logic                            viol_o,
  output logic [BA_W-1:0]                 viol_bank_o,
  output viol_e                           viol_code_o
);
  logic             pall_add;
  logic [CNT_W:0]   rcd_sum;
  logic [CNT_W:0]   rp_need;
  logic             ras_hit;
  logic [BA_W-1:0]  ras_bank;
  logic             checked;

  // one extra recovery clock after precharge-all on the eight-bank variant
  if (PALL_EXTRA) begin : g_pall_extra
    assign pall_add = pall_i[bank_i];
  end else begin : g_pall_plain
    assign pall_add = 1'b0;
  end

  assign rcd_sum = {1'b0, since_act_i[bank_i]} + (CNT_W+1)'(al_i);
  assign rp_need = {1'b0, t_rp_i} + (CNT_W+1)'(pall_add);

  // descending scan so the lowest young bank wins
  always_comb begin
    ras_hit  = 1'b0;
    ras_bank = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (active_i[b] && (since_act_i[b] < t_ras_i)) begin
        ras_hit  = 1'b1;
        ras_bank = BA_W'(b);
      end
    end
  end

  always_comb begin
    viol_code_o = VC_NONE;
    viol_bank_o = bank_i;
    checked     = 1'b0;
    case (cmd_i)
      CMD_ACT: begin
        checked = 1'b1;
        if (active_i[bank_i])                               viol_code_o = VC_OPEN;
        else if (since_act_i[bank_i] < t_rc_i)              viol_code_o = VC_RC;
        else if ({1'b0, since_pre_i[bank_i]} < rp_need)     viol_code_o = VC_RP;
        else if (since_any_act_i < t_rrd_i)                 viol_code_o = VC_RRD;
      end
      CMD_RD, CMD_WR: begin
        checked = 1'b1;
        if (!active_i[bank_i])                viol_code_o = VC_IDLE;
        else if (rcd_sum < {1'b0, t_rcd_i})   viol_code_o = VC_RCD;
      end
      CMD_PRE: begin
        checked = 1'b1;
        if (pre_all_i) begin
          if (ras_hit) begin
            viol_code_o = VC_RAS;
            viol_bank_o = ras_bank;
          end
        end else if (active_i[bank_i] && (since_act_i[bank_i] < t_ras_i)) begin
          viol_code_o = VC_RAS;
        end
      end
      default: checked = 1'b0;
    endcase
  end

  assign viol_o = checked && (viol_code_o != VC_NONE);
  assign ok_o   = checked && (viol_code_o == VC_NONE);
endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 6,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int AL_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             ras_n_i,
  input  logic             cas_n_i,
  input  logic             we_n_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic             pre_all_sel_i,
  input  logic [CNT_W-1:0] t_rcd_i,
  input  logic [CNT_W-1:0] t_ras_i,
  input  logic [CNT_W-1:0] t_rp_i,
  input  logic [CNT_W-1:0] t_rc_i,
  input  logic [CNT_W-1:0] t_rrd_i,
  input  logic [AL_W-1:0]  al_i,
  output logic             cmd_ok_o,
  output logic             viol_o,
  output logic [BA_W-1:0]  viol_bank_o,
  output logic [2:0]       viol_code_o
);
  localparam bit PALL_EXTRA = (NUM_BANKS == 8);

  cmd_e                            cmd;
  logic                            pre_all;
  logic [NUM_BANKS-1:0]            act_hit;
  logic [NUM_BANKS-1:0]            pre_hit;
  logic [NUM_BANKS-1:0]            active;
  logic [NUM_BANKS-1:0]            pall;
  logic [NUM_BANKS-1:0][CNT_W-1:0] since_act;
  logic [NUM_BANKS-1:0][CNT_W-1:0] since_pre;
  logic [CNT_W-1:0]                since_any_act;
  viol_e                           code;

  ddr2_cmd_decode i_decode (
    .cs_n_i        (cs_n_i),
    .ras_n_i       (ras_n_i),
    .cas_n_i       (cas_n_i),
    .we_n_i        (we_n_i),
    .pre_all_sel_i (pre_all_sel_i),
    .cmd_o         (cmd),
    .pre_all_o     (pre_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_hit[b] = (cmd == CMD_ACT) && (ba_i == BA_W'(b));
    assign pre_hit[b] = (cmd == CMD_PRE) && (pre_all || (ba_i == BA_W'(b)));

    ddr2_bank_track #(.CNT_W(CNT_W)) i_track (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_i       (act_hit[b]),
      .pre_i       (pre_hit[b]),
      .pre_all_i   (pre_all),
      .active_o    (active[b]),
      .pall_o      (pall[b]),
      .since_act_o (since_act[b]),
      .since_pre_o (since_pre[b])
    );
  end

  ddr2_sat_cnt #(.CNT_W(CNT_W)) i_any_act_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cmd == CMD_ACT),
    .cnt_o  (since_any_act)
  );

  ddr2_rule_check #(
    .NUM_BANKS  (NUM_BANKS),
    .CNT_W      (CNT_W),
    .AL_W       (AL_W),
    .PALL_EXTRA (PALL_EXTRA)
  ) i_rules (
    .cmd_i           (cmd),
    .bank_i          (ba_i),
    .pre_all_i       (pre_all),
    .active_i        (active),
    .pall_i          (pall),
    .since_act_i     (since_act),
    .since_pre_i     (since_pre),
    .since_any_act_i (since_any_act),
    .t_rcd_i         (t_rcd_i),
    .t_ras_i         (t_ras_i),
    .t_rp_i          (t_rp_i),
    .t_rc_i          (t_rc_i),
    .t_rrd_i         (t_rrd_i),
    .al_i            (al_i),
    .ok_o            (cmd_ok_o),
    .viol_o          (viol_o),
    .viol_bank_o     (viol_bank_o),
    .viol_code_o     (code)
  );

  assign viol_code_o = code;
endmodule

// File: rtl/ddr2_bank_guard_chk.sv
module ddr2_bank_guard_chk #(
  parameter int BA_W  = 3,
  parameter int CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_i,
  input logic             ras_n_i,
  input logic             cas_n_i,
  input logic             we_n_i,
  input logic [BA_W-1:0]  ba_i,
  input logic             pre_all_sel_i,
  input logic [CNT_W-1:0] t_ras_i,
  input logic [CNT_W-1:0] t_rrd_i,
  input logic             cmd_ok_o,
  input logic             viol_o,
  input logic [BA_W-1:0]  viol_bank_o,
  input logic [2:0]       viol_code_o
);
  logic is_act, is_rd, is_wr, is_pre, any_cmd, armed;

  assign is_act  = !cs_n_i && !ras_n_i &&  cas_n_i &&  we_n_i;
  assign is_rd   = !cs_n_i &&  ras_n_i && !cas_n_i &&  we_n_i;
  assign is_wr   = !cs_n_i &&  ras_n_i && !cas_n_i && !we_n_i;
  assign is_pre  = !cs_n_i && !ras_n_i &&  cas_n_i && !we_n_i;
  assign any_cmd = is_act || is_rd || is_wr || is_pre;

  // $past is trusted only once a full cycle out of reset has been seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_cmd |-> (!cmd_ok_o && !viol_o));

  assert_one_verdict_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cmd |-> (cmd_ok_o ^ viol_o));

  assert_code_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (viol_code_o != 3'd0));

  assert_rrd_next_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && is_act && (t_rrd_i > CNT_W'(1)) && $past(is_act)) |-> viol_o);

  assert_closed_bank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && (is_rd || is_wr) && $past(is_pre) && !$past(pre_all_sel_i)
     && (ba_i == $past(ba_i))) |-> (viol_o && viol_code_o == 3'd5));

  assert_early_pre_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && is_pre && !pre_all_sel_i && (t_ras_i > CNT_W'(1)) && $past(is_act)
     && (ba_i == $past(ba_i))) |-> (viol_o && viol_code_o == 3'd7 && viol_bank_o == ba_i));
endmodule

bind ddr2_bank_guard ddr2_bank_guard_chk #(.BA_W(BA_W), .CNT_W(CNT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_n_i        (cs_n_i),
  .ras_n_i       (ras_n_i),
  .cas_n_i       (cas_n_i),
  .we_n_i        (we_n_i),
  .ba_i          (ba_i),
  .pre_all_sel_i (pre_all_sel_i),
  .t_ras_i       (t_ras_i),
  .t_rrd_i       (t_rrd_i),
  .cmd_ok_o      (cmd_ok_o),
  .viol_o        (viol_o),
  .viol_bank_o   (viol_bank_o),
  .viol_code_o   (viol_code_o)
);

// File: tb/test_ddr2_bank_guard.sv
`timescale 1ns/1ps
module test_ddr2_bank_guard;
  localparam int NB = 8;
  localparam int CW = 6;
  localparam int SATV = 63;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [2:0] ba_i = '0;
  logic pre_all_sel_i = 1'b0;
  int trcd = 3, tras = 5, trp = 3, trc = 9, trrd = 2, al = 0;
  logic cmd_ok_o, viol_o;
  logic [2:0] viol_bank_o, viol_code_o;

  ddr2_bank_guard #(.NUM_BANKS(NB), .CNT_W(CW)) i_ddr2_bank_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .ba_i(ba_i), .pre_all_sel_i(pre_all_sel_i),
    .t_rcd_i(CW'(trcd)), .t_ras_i(CW'(tras)), .t_rp_i(CW'(trp)), .t_rc_i(CW'(trc)),
    .t_rrd_i(CW'(trrd)), .al_i(3'(al)), .cmd_ok_o(cmd_ok_o), .viol_o(viol_o),
    .viol_bank_o(viol_bank_o), .viol_code_o(viol_code_o));

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit act_st[NB];
  bit pall_st[NB];
  int last_act[NB];
  int last_pre[NB];
  int last_any;
  logic [15:0] lfsr = 16'hACE1;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: R2 run did not complete, actual=hung expected=finished");
    summary();
  end

  function automatic int gap(int now, int t);
    return (now - t > SATV) ? SATV : now - t;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NB; k++) begin
      act_st[k] = 0; pall_st[k] = 0; last_act[k] = -100000; last_pre[k] = -100000;
    end
    last_any = -100000;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    {cs_n_i, ras_n_i, cas_n_i, we_n_i} = 4'b0111;
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_clear();
  endtask

  task automatic set_t(int rcd, int ras, int rp, int rc, int rrd, int a);
    trcd = rcd; tras = ras; trp = rp; trc = rc; trrd = rrd; al = a;
  endtask

  function automatic string tag_of(int c, bit all, int code);
    case (code)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      7: return all ? "R10" : "R9";
      default: ;
    endcase
    case (c)
      1: return "R6";
      2, 3: return "R8";
      4: return all ? "R10" : "R9";
      default: return "R1";
    endcase
  endfunction

  // c: 0 nop, 1 activate, 2 read, 3 write, 4 precharge
  task automatic issue(int c, int b, bit all, string tag);
    int now, ecode, ebank;
    bit eok, ev;
    string t;
    @(negedge clk_i);
    case (c)
      1: {cs_n_i, ras_n_i, cas_n_i, we_n_i} = 4'b0011;
      2: {cs_n_i, ras_n_i, cas_n_i, we_n_i} = 4'b0101;
      3: {cs_n_i, ras_n_i, cas_n_i, we_n_i} = 4'b0100;
      4: {cs_n_i, ras_n_i, cas_n_i, we_n_i} = 4'b0010;
      default: {cs_n_i, ras_n_i, cas_n_i, we_n_i} = 4'b0111;
    endcase
    ba_i = 3'(b);
    pre_all_sel_i = all;
    #2;
    now = cyc;
    ecode = 0; ebank = b;
    case (c)
      1: begin
        if (act_st[b]) ecode = 1;
        else if (gap(now, last_act[b]) < trc) ecode = 2;
        else if (gap(now, last_pre[b]) < trp + int'(pall_st[b])) ecode = 3;
        else if (gap(now, last_any) < trrd) ecode = 4;
      end
      2, 3: begin
        if (!act_st[b]) ecode = 5;
        else if (gap(now, last_act[b]) + al < trcd) ecode = 6;
      end
      4: begin
        if (all) begin
          for (int k = NB - 1; k >= 0; k--)
            if (act_st[k] && gap(now, last_act[k]) < tras) begin ecode = 7; ebank = k; end
        end else if (act_st[b] && gap(now, last_act[b]) < tras) ecode = 7;
      end
      default: ;
    endcase
    ev = (c != 0) && (ecode != 0);
    eok = (c != 0) && (ecode == 0);
    t = (tag == "") ? tag_of(c, all, ecode) : tag;
    checks++;
    if (cmd_ok_o !== eok || viol_o !== ev || (ev && (int'(viol_code_o) != ecode
        || int'(viol_bank_o) != ebank))) begin
      fails++;
      $display("FAIL %s cyc=%0d cmd=%0d bank=%0d: actual ok=%0b viol=%0b code=%0d bank=%0d expected ok=%0b viol=%0b code=%0d bank=%0d",
               t, now, c, b, cmd_ok_o, viol_o, viol_code_o, viol_bank_o, eok, ev, ecode, ebank);
    end
    @(posedge clk_i);
    if (c == 1) begin act_st[b] = 1; last_act[b] = now; last_any = now; end
    if (c == 4)
      for (int k = 0; k < NB; k++)
        if (all || k == b) begin act_st[k] = 0; last_pre[k] = now; pall_st[k] = all; end
  endtask

  task automatic quiet_raw(logic [3:0] pins, string tag);
    @(negedge clk_i);
    {cs_n_i, ras_n_i, cas_n_i, we_n_i} = pins;
    #2;
    checks++;
    if (cmd_ok_o !== 1'b0 || viol_o !== 1'b0) begin
      fails++;
      $display("FAIL %s pins=%b: actual ok=%0b viol=%0b expected ok=0 viol=0",
               tag, pins, cmd_ok_o, viol_o);
    end
    @(posedge clk_i);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0, "R1");
  endtask

  initial begin
    model_clear();
    // R11: reset state and first activate under the largest limits
    set_t(63, 63, 63, 63, 63, 6);
    do_reset();
    issue(0, 0, 0, "R11");
    issue(1, 7, 0, "R11");
    // R1: deselected and unused patterns stay silent
    quiet_raw(4'b1011, "R1");
    quiet_raw(4'b1101, "R1");
    quiet_raw(4'b0110, "R1");
    quiet_raw(4'b0001, "R1");

    // R8: read gap sweep over every additive latency
    for (int a = 0; a <= 6; a++)
      for (int g = 1; g <= 6; g++) begin
        set_t(5, 5, 3, 9, 2, a);
        do_reset();
        issue(1, 0, 0, "R11");
        nops(g - 1);
        issue((g % 2) ? 2 : 3, 0, 0, "R8");
      end

    // R9: precharge gap sweep around tRAS, and precharge of an idle bank
    for (int g = 1; g <= 7; g++) begin
      set_t(3, 5, 3, 9, 2, 0);
      do_reset();
      issue(4, 2, 0, "R9");
      issue(1, 1, 0, "R6");
      nops(g - 1);
      issue(4, 1, 0, "R9");
      issue(2, 1, 0, "R7");
    end

    // R3, R7, R6, R12
    set_t(3, 5, 3, 9, 2, 0);
    do_reset();
    issue(2, 4, 0, "R7");
    issue(1, 0, 0, "R6");
    issue(1, 1, 0, "R6");
    issue(1, 0, 0, "R12");
    nops(1);
    issue(1, 2, 0, "R6");
    issue(1, 2, 0, "R3");

    // R5 and R4: precharge recovery, single and all-bank, row cycle
    for (int g = 1; g <= 5; g++) begin
      set_t(3, 5, 3, 9, 2, 0);
      do_reset();
      issue(1, 3, 0, "R6");
      nops(5);
      issue(4, 3, g > 2, "R5");
      nops(g - 1);
      issue(1, 3, 0, "R5");
    end
    for (int g = 6; g <= 10; g++) begin
      set_t(3, 2, 2, 8, 1, 0);
      do_reset();
      issue(1, 5, 0, "R4");
      nops(1);
      issue(4, 5, 0, "R9");
      nops(g - 3);
      issue(1, 5, 0, "R4");
    end

    // R10: precharge-all with young banks, then banks are idle
    set_t(3, 5, 3, 9, 1, 0);
    do_reset();
    issue(1, 6, 0, "R6");
    nops(3);
    issue(1, 2, 0, "R6");
    issue(1, 4, 0, "R6");
    issue(4, 0, 1, "R10");
    issue(2, 2, 0, "R10");
    issue(3, 6, 0, "R10");

    // R12: saturation of long gaps
    set_t(3, 5, 3, 63, 2, 0);
    do_reset();
    issue(1, 1, 0, "R12");
    nops(5);
    issue(4, 1, 0, "R9");
    nops(70);
    issue(1, 1, 0, "R12");

    // mixed command streams, checked against the cycle-stamped model
    for (int a = 0; a <= 6; a++) begin
      set_t(4, 6, 3, 10, 2, a);
      do_reset();
      for (int n = 0; n < 2000; n++) begin
        int r, c;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r = int'(lfsr);
        case (r % 8)
          0, 1: c = 0;
          2, 3: c = 1;
          4: c = 2;
          5: c = 3;
          default: c = 4;
        endcase
        issue(c, (r >> 4) % NB, ((r >> 8) % 5) == 0, "");
      end
    end

    summary();
  end
endmodule